// File: doc/BRIEF.md
# Autonegotiation Speed Downshift Controller

This controller sits next to an Ethernet autonegotiation engine and decides which link speeds the engine offers. After reset every speed the host enabled is offered. Each failed link-up attempt is counted. When the count reaches a programmable limit, the controller withdraws the fastest speed still on offer and asks the engine to restart negotiation. Failures at the slower level step it down again.

Once the slowest permitted level has also run out of attempts, the controller returns to offering every speed and begins the walk again. A configuration bit limits the walk so that it stops short of 10 Mb/s. A successful link-up clears the failure count, so the current offer stays in place until the link is lost and attempts start failing again. When the feature is switched off, the host's base advertisement passes straight through.

The speed vector is `NUM_SPEEDS` bits wide with the slowest speed in bit 0. In the default three-speed build, bit 2 is 1000 Mb/s, bit 1 is 100 Mb/s and bit 0 is 10 Mb/s.

Top module: `spd_downshift_ctrl`

## Requirements
- R1: While `srst_i` is high, `level_o` is 0, `restart_o` is 0 and `adv_mask_o` is 0, and the failure count is cleared. In the first cycle after reset is released, `adv_mask_o` equals `base_adv_i`.
- R2: `adv_mask_o` is registered with one cycle of latency. When downshift is enabled it equals `base_adv_i` ANDed with the allowed set of the current level. Level L clears the L highest bits, so in the three-speed build level 0 keeps bits 2..0, level 1 keeps bits 1..0 and level 2 keeps only bit 0.
- R3: With `limit_sel_i` = N (a 2-bit field), the (N+1)-th counted failure at a level causes a level change. That is 1, 2, 3 or 4 failures for N = 0, 1, 2 or 3.
- R4: With `allow_low_i` = 1, successive level changes go 0 → 1 → 2, and a level change requested at level 2 returns to level 0.
- R5: With `allow_low_i` = 0, the walk goes 0 → 1, and a level change requested at level 1 (or above) returns to level 0.
- R6: `restart_o` is high for exactly one cycle after each enabled level change. It appears in the cycle after the triggering failure pulse is sampled, which is the same cycle the new `level_o` and `adv_mask_o` appear.
- R7: A `link_up_i` pulse clears the failure count. If `attempt_fail_i` and `link_up_i` are high in the same cycle, the link-up wins and the failure is not counted.
- R8: While `ds_enable_i` is 0, failures are ignored, the count is held at 0, `level_o` returns to 0 with no restart pulse, and `adv_mask_o` follows `base_adv_i`.
- R9: The failure count restarts from zero after every level change and every wrap, so each new level again needs N+1 failures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| srst_i | input | 1 | Synchronous active-high reset |
| ds_enable_i | input | 1 | Enables the downshift walk |
| allow_low_i | input | 1 | Permits stepping down to the slowest speed only |
| limit_sel_i | input | LIMIT_W | Failures per level minus one |
| base_adv_i | input | NUM_SPEEDS | Host-enabled speeds, slowest in bit 0 |
| attempt_fail_i | input | 1 | One-cycle pulse: a link-up attempt failed |
| link_up_i | input | 1 | One-cycle pulse: the link came up |
| adv_mask_o | output | NUM_SPEEDS | Speeds to advertise |
| restart_o | output | 1 | One-cycle request to restart negotiation |
| level_o | output | LVL_W | Current downshift level, 0 means all speeds |

## Verification
The assertions assume that `attempt_fail_i` and `link_up_i` are single-cycle pulses. They also assume that configuration and the base advertisement change only while no pulse is in flight, so the registered mask can be compared against the previous cycle's base. The bench drives every input on the falling clock edge. It raises each event pulse for exactly one cycle and holds it low for the cycle after, and it changes configuration only between pulses. This keeps the stimulus inside those assumptions while sweeping every limit value, both fallback settings and several base patterns.

// File: rtl/spd_ds_pkg.sv
package spd_ds_pkg;

  // Deepest level reachable before the walk wraps back to level 0.
  function automatic int unsigned deepest_level(input int unsigned nspd,
                                                input logic allow_low);
    return allow_low ? (nspd - 1) : (nspd - 2);
  endfunction

endpackage

// File: rtl/spd_ds_fail_counter.sv
module spd_ds_fail_counter #(
  parameter int LIMIT_W = 2
) (
  input  logic               clk_i,
  input  logic               srst_i,
  input  logic               enable_i,
  input  logic               link_up_i,
  input  logic               fail_i,
  input  logic [LIMIT_W-1:0] limit_sel_i,
  output logic [LIMIT_W-1:0] cnt_o,
  output logic               reach_o
);
  localparam int EXT_W = LIMIT_W + 1;

  logic [LIMIT_W-1:0] cnt_q;
  logic [EXT_W-1:0]   cnt_inc;
  logic [EXT_W-1:0]   limit_val;

  assign cnt_inc   = {1'b0, cnt_q} + EXT_W'(1);
  assign limit_val = {1'b0, limit_sel_i} + EXT_W'(1);
  assign reach_o   = enable_i & fail_i & ~link_up_i & (cnt_inc >= limit_val);

  always_ff @(posedge clk_i) begin
    if (srst_i || !enable_i || link_up_i) begin
      cnt_q <= '0;
    end else if (fail_i) begin
      if (reach_o) cnt_q <= '0;
      else         cnt_q <= cnt_inc[LIMIT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/spd_ds_level_stepper.sv
module spd_ds_level_stepper
  import spd_ds_pkg::*;
#(
  parameter int NUM_SPEEDS = 3,
  parameter int LVL_W      = $clog2(NUM_SPEEDS)
) (
  input  logic             clk_i,
  input  logic             srst_i,
  input  logic             enable_i,
  input  logic             allow_low_i,
  input  logic             step_i,
  output logic [LVL_W-1:0] level_d_o,
  output logic [LVL_W-1:0] level_q_o,
  output logic             restart_q_o
);
  logic [LVL_W-1:0] level_q;
  logic [LVL_W-1:0] last_lvl;
  logic             restart_q;

  assign last_lvl = LVL_W'(deepest_level(NUM_SPEEDS, allow_low_i));

  always_comb begin
    level_d_o = level_q;
    if (!enable_i) begin
      level_d_o = '0;
    end else if (step_i) begin
      if (level_q >= last_lvl) level_d_o = '0;
      else                     level_d_o = level_q + LVL_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      level_q   <= '0;
      restart_q <= 1'b0;
    end else begin
      level_q   <= level_d_o;
      restart_q <= enable_i & step_i;
    end
  end

  assign level_q_o   = level_q;
  assign restart_q_o = restart_q;
endmodule

// File: rtl/spd_ds_adv_mask.sv
module spd_ds_adv_mask #(
  parameter int NUM_SPEEDS = 3,
  parameter int LVL_W      = $clog2(NUM_SPEEDS)
) (
  input  logic                  clk_i,
  input  logic                  srst_i,
  input  logic                  enable_i,
  input  logic [NUM_SPEEDS-1:0] base_i,
  input  logic [LVL_W-1:0]      level_i,
  output logic [NUM_SPEEDS-1:0] mask_o
);
  logic [NUM_SPEEDS-1:0] keep;
  logic [NUM_SPEEDS-1:0] mask_q;

  // Bit i survives while i + level stays below the speed count.
  for (genvar i = 0; i < NUM_SPEEDS; i++) begin : g_keep
    assign keep[i] = (32'(i) + 32'(level_i)) < 32'(NUM_SPEEDS);
  end

  always_ff @(posedge clk_i) begin
    if (srst_i)         mask_q <= '0;
    else if (!enable_i) mask_q <= base_i;
    else                mask_q <= base_i & keep;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/spd_downshift_ctrl.sv
module spd_downshift_ctrl #(
  parameter int NUM_SPEEDS = 3,
  parameter int LIMIT_W    = 2,
  parameter int LVL_W      = $clog2(NUM_SPEEDS)
) (
  input  logic                  clk_i,
  input  logic                  srst_i,
  input  logic                  ds_enable_i,
  input  logic                  allow_low_i,
  input  logic [LIMIT_W-1:0]    limit_sel_i,
  input  logic [NUM_SPEEDS-1:0] base_adv_i,
  input  logic                  attempt_fail_i,
  input  logic                  link_up_i,
  output logic [NUM_SPEEDS-1:0] adv_mask_o,
  output logic                  restart_o,
  output logic [LVL_W-1:0]      level_o
);
  logic [LIMIT_W-1:0] fail_cnt;
  logic               step;
  logic [LVL_W-1:0]   level_d;

  spd_ds_fail_counter #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk_i       (clk_i),
    .srst_i      (srst_i),
    .enable_i    (ds_enable_i),
    .link_up_i   (link_up_i),
    .fail_i      (attempt_fail_i),
    .limit_sel_i (limit_sel_i),
    .cnt_o       (fail_cnt),
    .reach_o     (step)
  );

  spd_ds_level_stepper #(.NUM_SPEEDS(NUM_SPEEDS), .LVL_W(LVL_W)) u_step (
    .clk_i       (clk_i),
    .srst_i      (srst_i),
    .enable_i    (ds_enable_i),
    .allow_low_i (allow_low_i),
    .step_i      (step),
    .level_d_o   (level_d),
    .level_q_o   (level_o),
    .restart_q_o (restart_o)
  );

  spd_ds_adv_mask #(.NUM_SPEEDS(NUM_SPEEDS), .LVL_W(LVL_W)) u_mask (
    .clk_i    (clk_i),
    .srst_i   (srst_i),
    .enable_i (ds_enable_i),
    .base_i   (base_adv_i),
    .level_i  (level_d),
    .mask_o   (adv_mask_o)
  );
endmodule

// File: rtl/spd_ds_checker.sv
module spd_ds_checker #(
  parameter int NUM_SPEEDS = 3,
  parameter int LIMIT_W    = 2,
  parameter int LVL_W      = $clog2(NUM_SPEEDS)
) (
  input logic                  clk_i,
  input logic                  srst_i,
  input logic                  ds_enable_i,
  input logic                  allow_low_i,
  input logic                  link_up_i,
  input logic [NUM_SPEEDS-1:0] base_adv_i,
  input logic [NUM_SPEEDS-1:0] adv_mask_o,
  input logic                  restart_o,
  input logic [LVL_W-1:0]      level_o,
  input logic [LIMIT_W-1:0]    fail_cnt
);
  assert_restart_single_R6: assert property (@(posedge clk_i) disable iff (srst_i)
    restart_o |=> !restart_o);

  assert_restart_on_change_R6: assert property (@(posedge clk_i) disable iff (srst_i)
    ((level_o != $past(level_o)) && $past(ds_enable_i)) |-> restart_o);

  assert_mask_subset_R2: assert property (@(posedge clk_i) disable iff (srst_i)
    (adv_mask_o & ~$past(base_adv_i)) == '0);

  assert_disabled_idle_R8: assert property (@(posedge clk_i) disable iff (srst_i)
    !ds_enable_i |=> (level_o == '0) && (fail_cnt == '0) && !restart_o);

  assert_link_clears_R7: assert property (@(posedge clk_i) disable iff (srst_i)
    link_up_i |=> (fail_cnt == '0));

  assert_level_range_R4: assert property (@(posedge clk_i) disable iff (srst_i)
    32'(level_o) <= NUM_SPEEDS - 1);

  assert_no_low_level_R5: assert property (@(posedge clk_i) disable iff (srst_i)
    (!allow_low_i && !$past(allow_low_i) && (32'($past(level_o)) < NUM_SPEEDS - 1))
      |-> (32'(level_o) < NUM_SPEEDS - 1));
endmodule

bind spd_downshift_ctrl spd_ds_checker #(
  .NUM_SPEEDS(NUM_SPEEDS), .LIMIT_W(LIMIT_W), .LVL_W(LVL_W)
) u_chk (
  .clk_i       (clk_i),
  .srst_i      (srst_i),
  .ds_enable_i (ds_enable_i),
  .allow_low_i (allow_low_i),
  .link_up_i   (link_up_i),
  .base_adv_i  (base_adv_i),
  .adv_mask_o  (adv_mask_o),
  .restart_o   (restart_o),
  .level_o     (level_o),
  .fail_cnt    (fail_cnt)
);

// File: tb/spd_downshift_ctrl_tb_top.sv
`timescale 1ns/1ps
module spd_downshift_ctrl_tb_top;
  localparam int NS = 3;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          srst_i = 1'b1;
  logic          ds_enable_i = 1'b1;
  logic          allow_low_i = 1'b1;
  logic [LW-1:0] limit_sel_i = '0;
  logic [NS-1:0] base_adv_i = '1;
  logic          attempt_fail_i = 1'b0;
  logic          link_up_i = 1'b0;
  logic [NS-1:0] adv_mask_o;
  logic          restart_o;
  logic [1:0]    level_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference state
  int m_level = 0;
  int m_cnt = 0;
  bit m_restart = 0;

  always #2.5 clk = ~clk;

  spd_downshift_ctrl #(.NUM_SPEEDS(NS), .LIMIT_W(LW)) dut_i (
    .clk_i(clk), .srst_i(srst_i), .ds_enable_i(ds_enable_i),
    .allow_low_i(allow_low_i), .limit_sel_i(limit_sel_i),
    .base_adv_i(base_adv_i), .attempt_fail_i(attempt_fail_i),
    .link_up_i(link_up_i), .adv_mask_o(adv_mask_o),
    .restart_o(restart_o), .level_o(level_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_mask();
    if (!ds_enable_i) return int'(base_adv_i);
    return int'(base_adv_i) & ((1 << (NS - m_level)) - 1);
  endfunction

  task automatic check_outputs(input string tag);
    chk(tag, "level", int'(level_o), m_level);
    chk(tag, "restart", int'(restart_o), int'(m_restart));
    chk(tag, "mask", int'(adv_mask_o), exp_mask());
  endtask

  // one cycle with the given event inputs, then one idle cycle
  task automatic pulse(input bit fail, input bit link, input string tag);
    int last;
    attempt_fail_i = fail;
    link_up_i = link;
    @(negedge clk);
    attempt_fail_i = 1'b0;
    link_up_i = 1'b0;
    m_restart = 0;
    last = allow_low_i ? NS - 1 : NS - 2;
    if (!ds_enable_i) begin
      m_level = 0; m_cnt = 0;
    end else if (link) begin
      m_cnt = 0;
    end else if (fail) begin
      if (m_cnt + 1 >= int'(limit_sel_i) + 1) begin
        m_level = (m_level >= last) ? 0 : m_level + 1;
        m_cnt = 0;
        m_restart = 1;
      end else begin
        m_cnt++;
      end
    end
    check_outputs(tag);
    @(negedge clk);
    m_restart = 0;
    check_outputs({tag, " idle"});
  endtask

  task automatic do_reset();
    srst_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "reset level", int'(level_o), 0);
    chk("R1", "reset restart", int'(restart_o), 0);
    chk("R1", "reset mask", int'(adv_mask_o), 0);
    srst_i = 1'b0;
    m_level = 0; m_cnt = 0; m_restart = 0;
    @(negedge clk);
    chk("R1", "first mask", int'(adv_mask_o), int'(base_adv_i));
  endtask

  task automatic set_enable(input bit en);
    ds_enable_i = en;
    @(negedge clk);
    if (!en) begin m_level = 0; m_cnt = 0; end
    m_restart = 0;
    check_outputs("R8 enable change");
  endtask

  task automatic run_combo(input int sel, input bit al, input logic [NS-1:0] base);
    int nlev;
    limit_sel_i = LW'(sel);
    allow_low_i = al;
    base_adv_i = base;
    ds_enable_i = 1'b1;
    do_reset();
    nlev = al ? NS : NS - 1;
    // two full laps of the walk, including the wrap (R2 R3 R4 R5 R6 R9)
    for (int lap = 0; lap < 2; lap++)
      for (int lv = 0; lv < nlev; lv++)
        for (int k = 0; k <= sel; k++)
          pulse(1'b1, 1'b0, al ? "R3 R4 R6 R9" : "R3 R5 R6 R9");
    // partial count then link-up: count must start over (R7)
    for (int k = 0; k < sel; k++) pulse(1'b1, 1'b0, "R7 pre");
    pulse(1'b0, 1'b1, "R7 link");
    for (int k = 0; k < sel; k++) pulse(1'b1, 1'b0, "R7 after link");
    pulse(1'b1, 1'b1, "R7 simultaneous");
    pulse(1'b1, 1'b0, "R7 post");
    // move off level 0, then disable (R8)
    for (int k = 0; k <= sel; k++) pulse(1'b1, 1'b0, "R2 step");
    set_enable(1'b0);
    for (int k = 0; k < 6; k++) pulse(1'b1, 1'b0, "R8 disabled fail");
    set_enable(1'b1);
    for (int k = 0; k <= sel; k++) pulse(1'b1, 1'b0, "R8 re-enabled");
  endtask

  initial begin
    logic [NS-1:0] bases [4];
    bases[0] = 3'b111; bases[1] = 3'b101; bases[2] = 3'b110; bases[3] = 3'b011;
    @(negedge clk);
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 4; b++)
          run_combo(s, a[0], bases[b]);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule